// File: doc/BRIEF.md
# Hierarchy Traversal List Stack Engine

This controller runs the pointer bookkeeping for hierarchical collision checks between two binary bounding-volume trees. One tree is walked level by level. For each level it keeps two lists of node pointers taken from the other tree: a left list and a right list. Each list holds nodes that still have to be tested for overlap. The engine reads the list it is working on, one pointer at a time, and sends each pointer out on a request port. For each request it receives a response carrying two child pointers and the result of the overlap test. It then decides which child pointers are kept and written into the lists one level further down.

Each branch has its own single-port-per-direction list store. All lists of one branch lie back to back in that branch's store. A bank of marker registers records, for every level, where each list starts, how long it is and whether it still has to be processed. Reads always come from the current level and appends always go to the level below it. When a list is used up, the engine first moves down a level. It then climbs back up through the levels until it finds a list that is still pending. When no list is left at the top level, the traversal is complete.

Before a run, software loads the top-level lists through a small write port, normally with four sibling pairs. It then pulses `start` and serves requests until `done` pulses.

Top module: `lse_stack_engine`

## Requirements
- R1: Pointers of the list being processed are issued in the order they were written. Each pointer is held on `req_ptr` with `req_valid` high until `req_ready` is seen. No new request is raised until the response to the previous one has been accepted.
- R2: `req_branch` is 0 for a pointer read from the left store and 1 for one read from the right store. A response is accepted only when its `rsp_branch` equals the branch of the outstanding request. A response with any other tag is ignored.
- R3: When an accepted response has `rsp_tumbled` = 1, `rsp_child_l` is appended to the left list and `rsp_child_r` to the right list one level below, whatever the overlap bits say.
- R4: When `rsp_tumbled` = 0, `rsp_hit[0]` = 1 appends `rsp_child_l` to the left list one level below and `rsp_hit[1]` = 1 appends `rsp_child_r` to the right list. A child whose bit is 0 is dropped.
- R5: After a list is finished, the engine moves one level down. At any level it picks the left list if that list is pending, otherwise the right list. If neither is pending, it moves up one level and looks again.
- R6: When processing of a list at level L begins, both lists at level L+1 are reset to empty. They start in each store directly after that store's level-L list.
- R7: `done` is a one-cycle pulse, raised when level 0 has no pending list. After it, the level-0 lists are empty. A `start` with nothing loaded gives `done` without any request.
- R8: An append to a store that already holds STORE_DEPTH entries is dropped and sets `overflow`. `overflow` stays set until reset.
- R9: A child pointer produced while processing a list at level MAX_DEPTH-1 is dropped and sets `overflow`.
- R10: After reset the engine is idle: `req_valid`, `done` and `overflow` are 0.
- R11: While idle, `init_we` appends `init_ptr` to the level-0 list of `init_branch` (0 left, 1 right). While a traversal is running, `init_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_we | input | 1 | Load strobe for a level-0 pointer (idle only) |
| init_branch | input | 1 | Target list of the load: 0 left, 1 right |
| init_ptr | input | PTR_W | Pointer to load |
| start | input | 1 | Begin a traversal (idle only) |
| req_valid | output | 1 | Request pointer is valid |
| req_ready | input | 1 | Memory side takes the request |
| req_ptr | output | PTR_W | Node pointer requested |
| req_branch | output | 1 | Branch tag of the request |
| rsp_valid | input | 1 | Response present |
| rsp_branch | input | 1 | Branch tag echoed by the response |
| rsp_tumbled | input | 1 | Parents are tumbled nodes: keep both children |
| rsp_hit | input | 2 | Overlap flags, bit 0 left sibling, bit 1 right sibling |
| rsp_child_l | input | PTR_W | Child pointer for the left list |
| rsp_child_r | input | PTR_W | Child pointer for the right list |
| done | output | 1 | Traversal complete pulse |
| overflow | output | 1 | Sticky store or depth overflow |

## Verification
The delicate cycle is the response to the last pointer of a list. In that single cycle the engine appends up to two children at level L+1, retires the current list's pending mark at level L, and moves the level register. The bench provokes this on every list end. It uses random response delays, tumble-heavy responses that append to both stores at once, and single-pointer lists, where the first response is also the last.

Each case is judged against a reference traversal computed in the bench from the requirements. A lost append, a wrong retire or a wrong level step shows up as a divergence in the request order or the branch tags, or as a wrong request count before `done`.

// File: rtl/lse_pkg.sv
package lse_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_OPEN,
      ST_RD,
      ST_REQ,
      ST_WAIT,
      ST_FIN
   } lse_state_e;

   localparam int unsigned NUM_BR = 2;

endpackage

// File: rtl/lse_list_ram.sv
module lse_list_ram #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
      if (re) rdata <= mem_q[raddr];
   end

endmodule

// File: rtl/lse_marker_bank.sv
module lse_marker_bank #(
   parameter int unsigned LEVELS = 16,
   parameter int unsigned CW     = 7,
   localparam int unsigned LW    = $clog2(LEVELS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rd_lvl,
   output logic [CW-1:0] rd_start,
   output logic [CW-1:0] rd_len,
   output logic          rd_pend,
   input  logic [LW-1:0] wr_lvl,
   output logic [CW-1:0] wr_fill,
   input  logic          open_i,
   input  logic          append_i,
   input  logic          consume_i
);

   logic [CW-1:0] start_q [LEVELS];
   logic [CW-1:0] len_q   [LEVELS];
   logic [LEVELS-1:0] pend_q;
   logic [LW-1:0] prev_lvl;
   logic [CW-1:0] open_base;

   assign rd_start  = start_q[rd_lvl];
   assign rd_len    = len_q[rd_lvl];
   assign rd_pend   = pend_q[rd_lvl];
   assign wr_fill   = start_q[wr_lvl] + len_q[wr_lvl];
   assign prev_lvl  = wr_lvl - LW'(1);
   assign open_base = (wr_lvl == '0) ? '0 : start_q[prev_lvl] + len_q[prev_lvl];

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            start_q[l] <= '0;
            len_q[l]   <= '0;
            pend_q[l]  <= 1'b0;
         end else begin
            if (open_i && wr_lvl == LW'(l)) begin
               start_q[l] <= open_base;
               len_q[l]   <= '0;
               pend_q[l]  <= 1'b0;
            end else if (append_i && wr_lvl == LW'(l)) begin
               len_q[l]   <= len_q[l] + CW'(1);
               pend_q[l]  <= 1'b1;
            end else if (consume_i && rd_lvl == LW'(l)) begin
               pend_q[l]  <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/lse_stack_engine.sv
module lse_stack_engine
   import lse_pkg::*;
#(
   parameter int unsigned PTR_W       = 16,
   parameter int unsigned MAX_DEPTH   = 16,
   parameter int unsigned STORE_DEPTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_we,
   input  logic             init_branch,
   input  logic [PTR_W-1:0] init_ptr,
   input  logic             start,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [PTR_W-1:0] req_ptr,
   output logic             req_branch,
   input  logic             rsp_valid,
   input  logic             rsp_branch,
   input  logic             rsp_tumbled,
   input  logic [1:0]       rsp_hit,
   input  logic [PTR_W-1:0] rsp_child_l,
   input  logic [PTR_W-1:0] rsp_child_r,
   output logic             done,
   output logic             overflow
);

   localparam int unsigned LW = $clog2(MAX_DEPTH);
   localparam int unsigned AW = $clog2(STORE_DEPTH);
   localparam int unsigned CW = $clog2(STORE_DEPTH + 1);

   if (MAX_DEPTH < 2) begin : g_bad_depth
      $error("lse_stack_engine: MAX_DEPTH must be at least 2");
   end
   if (STORE_DEPTH < 4) begin : g_bad_store
      $error("lse_stack_engine: STORE_DEPTH must be at least 4");
   end
   if (PTR_W < 1) begin : g_bad_ptr
      $error("lse_stack_engine: PTR_W must be positive");
   end

   lse_state_e    state_q;
   logic [LW-1:0] lvl_q;
   logic          br_q;
   logic [CW-1:0] idx_q;
   logic          ovf_q;

   logic [LW-1:0] wr_lvl;
   logic          deep_full;
   logic          rsp_ok;
   logic          last_ptr;

   logic [CW-1:0]    rd_start [NUM_BR];
   logic [CW-1:0]    rd_len   [NUM_BR];
   logic [CW-1:0]    wr_fill  [NUM_BR];
   logic [PTR_W-1:0] ram_rd   [NUM_BR];
   logic [PTR_W-1:0] app_data [NUM_BR];
   logic [NUM_BR-1:0] rd_pend, want, blocked, do_app, do_open, do_cons, do_read;

   assign deep_full = (lvl_q == LW'(MAX_DEPTH - 1));
   assign wr_lvl    = (state_q == ST_IDLE || state_q == ST_FIN) ? '0 : lvl_q + LW'(1);
   assign rsp_ok    = (state_q == ST_WAIT) && rsp_valid && (rsp_branch == br_q);
   assign last_ptr  = ((idx_q + CW'(1)) == rd_len[br_q]);

   for (genvar b = 0; b < NUM_BR; b++) begin : g_br
      logic ld_hit;
      logic rs_hit;

      assign ld_hit      = (state_q == ST_IDLE) && init_we && (init_branch == 1'(b));
      assign rs_hit      = rsp_ok && (rsp_tumbled || rsp_hit[b]);
      assign want[b]     = ld_hit || rs_hit;
      assign blocked[b]  = (wr_fill[b] == CW'(STORE_DEPTH)) || (rs_hit && deep_full);
      assign do_app[b]   = want[b] && !blocked[b];
      assign do_open[b]  = ((state_q == ST_OPEN) && !deep_full) || (state_q == ST_FIN);
      assign do_cons[b]  = rsp_ok && last_ptr && (br_q == 1'(b));
      assign do_read[b]  = (state_q == ST_RD) && (br_q == 1'(b));
      assign app_data[b] = ld_hit ? init_ptr : ((b == 0) ? rsp_child_l : rsp_child_r);

      lse_marker_bank #(
         .LEVELS (MAX_DEPTH),
         .CW     (CW)
      ) u_mark (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd_lvl    (lvl_q),
         .rd_start  (rd_start[b]),
         .rd_len    (rd_len[b]),
         .rd_pend   (rd_pend[b]),
         .wr_lvl    (wr_lvl),
         .wr_fill   (wr_fill[b]),
         .open_i    (do_open[b]),
         .append_i  (do_app[b]),
         .consume_i (do_cons[b])
      );

      lse_list_ram #(
         .DATA_W (PTR_W),
         .DEPTH  (STORE_DEPTH)
      ) u_store (
         .clk   (clk),
         .we    (do_app[b]),
         .waddr (AW'(wr_fill[b])),
         .wdata (app_data[b]),
         .re    (do_read[b]),
         .raddr (AW'(rd_start[b] + idx_q)),
         .rdata (ram_rd[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lvl_q   <= '0;
         br_q    <= 1'b0;
         idx_q   <= '0;
         ovf_q   <= 1'b0;
      end else begin
         if (|(want & blocked)) ovf_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  lvl_q   <= '0;
                  state_q <= ST_SEL;
               end
            end
            ST_SEL: begin
               if (rd_pend[0]) begin
                  br_q    <= 1'b0;
                  state_q <= ST_OPEN;
               end else if (rd_pend[1]) begin
                  br_q    <= 1'b1;
                  state_q <= ST_OPEN;
               end else if (lvl_q == '0) begin
                  state_q <= ST_FIN;
               end else begin
                  lvl_q   <= lvl_q - LW'(1);
               end
            end
            ST_OPEN: begin
               idx_q   <= '0;
               state_q <= ST_RD;
            end
            ST_RD:   state_q <= ST_REQ;
            ST_REQ:  if (req_ready) state_q <= ST_WAIT;
            ST_WAIT: begin
               if (rsp_ok) begin
                  if (last_ptr) begin
                     if (!deep_full) lvl_q <= lvl_q + LW'(1);
                     state_q <= ST_SEL;
                  end else begin
                     idx_q   <= idx_q + CW'(1);
                     state_q <= ST_RD;
                  end
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid  = (state_q == ST_REQ);
   assign req_ptr    = ram_rd[br_q];
   assign req_branch = br_q;
   assign done       = (state_q == ST_FIN);
   assign overflow   = ovf_q;

endmodule

// File: rtl/lse_stack_engine_chk.sv
module lse_stack_engine_chk #(
   parameter int unsigned PTR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [PTR_W-1:0] req_ptr,
   input logic             req_branch,
   input logic             rsp_valid,
   input logic             rsp_branch,
   input logic             done,
   input logic             overflow
);

   logic pend_q;
   logic tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         tag_q  <= 1'b0;
      end else if (req_valid && req_ready) begin
         pend_q <= 1'b1;
         tag_q  <= req_branch;
      end else if (rsp_valid && pend_q && rsp_branch == tag_q) begin
         pend_q <= 1'b0;
      end
   end

   // R1: request held stable until taken
   p_hold_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_ptr) && $stable(req_branch));

   // R1: only one request outstanding
   p_single_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !req_valid);

   // R2: mistagged response leaves the engine waiting
   p_tag_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && rsp_valid && (rsp_branch != tag_q) |=> !req_valid && !done);

   // R7: done lasts one cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: done never with work in flight
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid && !pend_q);

   // R8: overflow is sticky
   p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

endmodule

bind lse_stack_engine lse_stack_engine_chk #(.PTR_W(PTR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_ptr    (req_ptr),
   .req_branch (req_branch),
   .rsp_valid  (rsp_valid),
   .rsp_branch (rsp_branch),
   .done       (done),
   .overflow   (overflow)
);

// File: tb/lse_stack_engine_tb.sv
module lse_stack_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int PTR_W      = 16;
   localparam int DEPTH      = 16;
   localparam int STORE      = 64;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             init_we, init_branch, start;
   logic [PTR_W-1:0] init_ptr;
   logic             req_valid, req_ready, req_branch;
   logic [PTR_W-1:0] req_ptr;
   logic             rsp_valid, rsp_branch, rsp_tumbled;
   logic [1:0]       rsp_hit;
   logic [PTR_W-1:0] rsp_child_l, rsp_child_r;
   logic             done, overflow;

   lse_stack_engine #(.PTR_W(PTR_W), .MAX_DEPTH(DEPTH), .STORE_DEPTH(STORE)) dut_i (
      .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_branch(init_branch),
      .init_ptr(init_ptr), .start(start), .req_valid(req_valid), .req_ready(req_ready),
      .req_ptr(req_ptr), .req_branch(req_branch), .rsp_valid(rsp_valid),
      .rsp_branch(rsp_branch), .rsp_tumbled(rsp_tumbled), .rsp_hit(rsp_hit),
      .rsp_child_l(rsp_child_l), .rsp_child_r(rsp_child_r), .done(done),
      .overflow(overflow));

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- reference traversal ----------------
   int mode;
   int ml [2][DEPTH][$];
   int olen [2][DEPTH];
   int exp_ptr[$];
   int exp_br[$];
   bit ovf_model = 1'b0;

   function automatic logic [31:0] mixh(input int p, input int salt);
      logic [31:0] x;
      x = (32'(p) * 32'h9E3779B1) ^ (32'(salt) * 32'h7F4A7C15);
      x = x ^ (x >> 15);
      x = x * 32'h85EBCA6B;
      x = x ^ (x >> 13);
      return x;
   endfunction

   function automatic bit f_tum(input int p);
      logic [31:0] h;
      h = mixh(p, 1);
      if (mode == 0) return h[2:0] == 3'd0;
      if (mode == 2) return h[1:0] == 2'd0;
      return 1'b0;
   endfunction

   function automatic bit f_hit(input int p, input int side);
      logic [31:0] h;
      h = mixh(p, 2 + side);
      if (mode == 0) return h[2:0] < 3'd3;
      if (mode == 1) return side == 0;
      return 1'b0;
   endfunction

   function automatic int f_child(input int p, input int side);
      return int'(mixh(p, 4 + side) & 32'hFFFF);
   endfunction

   function automatic int fill_of(input int x, input int lv);
      int s = 0;
      for (int k = 0; k <= lv; k++) s += olen[x][k];
      return s;
   endfunction

   task automatic model_run();
      int lvl = 0;
      int b;
      int cur[$];
      while (exp_ptr.size() < 5000) begin
         // R5: left first, then right, otherwise climb
         if (ml[0][lvl].size() > 0) b = 0;
         else if (ml[1][lvl].size() > 0) b = 1;
         else begin
            if (lvl == 0) break;
            lvl--;
            continue;
         end
         // R6: lists one level down start empty
         if (lvl + 1 < DEPTH) begin
            for (int x = 0; x < 2; x++) begin
               ml[x][lvl+1].delete();
               olen[x][lvl+1] = 0;
            end
         end
         cur = ml[b][lvl];
         ml[b][lvl].delete();
         foreach (cur[i]) begin
            exp_ptr.push_back(cur[i]);
            exp_br.push_back(b);
            for (int x = 0; x < 2; x++) begin
               if (f_tum(cur[i]) || f_hit(cur[i], x)) begin
                  if (lvl + 1 >= DEPTH || fill_of(x, lvl + 1) >= STORE) ovf_model = 1'b1;
                  else begin
                     ml[x][lvl+1].push_back(f_child(cur[i], x));
                     olen[x][lvl+1]++;
                  end
               end
            end
         end
         if (lvl + 1 < DEPTH) lvl++;
      end
   endtask

   // ---------------- one traversal ----------------
   task automatic run_case(input string tag, input int m, input int n_l,
                           input int n_r, input bit junk);
      int ib[$];
      int ip[$];
      int idx = 0;
      int cyc = 0;
      int dly = 0;
      bit waiting = 1'b0;
      bit seen_done = 1'b0;
      int cur_p = 0;
      bit cur_b = 1'b0;
      mode = m;
      for (int x = 0; x < 2; x++)
         for (int l = 0; l < DEPTH; l++) begin
            ml[x][l].delete();
            olen[x][l] = 0;
         end
      exp_ptr.delete();
      exp_br.delete();
      for (int i = 0; i < n_l + n_r; i++) begin
         ib.push_back(i < n_l ? 0 : 1);
         ip.push_back(int'($urandom & 32'hFFFF));
      end
      foreach (ib[i]) begin
         if (fill_of(ib[i], 0) >= STORE) ovf_model = 1'b1;
         else begin
            ml[ib[i]][0].push_back(ip[i]);
            olen[ib[i]][0]++;
         end
      end
      model_run();

      foreach (ib[i]) begin
         @(negedge clk);
         init_we = 1'b1;
         init_branch = ib[i][0];
         init_ptr = ip[i][PTR_W-1:0];
      end
      @(negedge clk);
      init_we = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;

      while (!seen_done && cyc < 60000) begin
         @(negedge clk);
         cyc++;
         rsp_valid = 1'b0;
         init_we = junk ? 1'($urandom & 1) : 1'b0;   // R11: ignored while busy
         init_ptr = PTR_W'($urandom);
         init_branch = 1'($urandom & 1);
         if (done) begin
            seen_done = 1'b1;
            init_we = 1'b0;
            req_ready = 1'b0;
         end else if (waiting) begin
            req_ready = 1'b0;
            if (dly == 0) begin
               rsp_valid   = 1'b1;
               rsp_branch  = cur_b;
               rsp_tumbled = f_tum(cur_p);
               rsp_hit     = {f_hit(cur_p, 1), f_hit(cur_p, 0)};
               rsp_child_l = PTR_W'(f_child(cur_p, 0));
               rsp_child_r = PTR_W'(f_child(cur_p, 1));
               waiting = 1'b0;
            end else begin
               if (junk && ($urandom & 1)) begin
                  // R2: wrong tag must be ignored
                  rsp_valid   = 1'b1;
                  rsp_branch  = ~cur_b;
                  rsp_tumbled = 1'b1;
                  rsp_hit     = 2'b11;
                  rsp_child_l = PTR_W'($urandom);
                  rsp_child_r = PTR_W'($urandom);
               end
               dly--;
            end
         end else begin
            req_ready = 1'($urandom & 1);
            if (req_valid && req_ready) begin
               if (idx < exp_ptr.size()) begin
                  check(req_ptr == PTR_W'(exp_ptr[idx]), tag, "R1 request pointer",
                        req_ptr, exp_ptr[idx]);
                  check(req_branch == exp_br[idx][0], tag, "R2 request branch",
                        req_branch, exp_br[idx]);
               end else begin
                  check(1'b0, tag, "R5 request beyond expected end", idx, exp_ptr.size());
               end
               cur_p = int'(req_ptr);
               cur_b = req_branch;
               idx++;
               waiting = 1'b1;
               dly = int'($urandom % 3);
            end
         end
      end
      check(seen_done, "R7", {tag, " done seen"}, seen_done, 1);
      check(idx == exp_ptr.size(), tag, "R5 request count", idx, exp_ptr.size());
      @(negedge clk);
      check(done == 1'b0, "R7", "done single cycle", done, 0);
      check(overflow == ovf_model, tag, "R8/R9 overflow flag", overflow, ovf_model);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- main ----------------
   initial begin
      int seed;
      seed = int'($urandom(32'd1234));
      rst_n = 1'b0;
      init_we = 1'b0; init_branch = 1'b0; init_ptr = '0; start = 1'b0;
      req_ready = 1'b0; rsp_valid = 1'b0; rsp_branch = 1'b0; rsp_tumbled = 1'b0;
      rsp_hit = 2'b00; rsp_child_l = '0; rsp_child_r = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: idle after reset
      check(req_valid == 1'b0, "R10", "req_valid after reset", req_valid, 0);
      check(done == 1'b0, "R10", "done after reset", done, 0);
      check(overflow == 1'b0, "R10", "overflow after reset", overflow, 0);

      run_case("R7", 4, 0, 0, 1'b0);          // empty start
      run_case("R5", 0, 2, 2, 1'b0);          // both top lists
      for (int i = 0; i < 6; i++) begin
         int nl;
         nl = 1 + int'($urandom % 4);
         run_case("R4/R11", 0, nl, 4 - nl, 1'b1);
      end
      for (int i = 0; i < 3; i++) run_case("R3", 2, 3, 1, 1'b1);
      run_case("R9", 1, 1, 0, 1'b0);          // single-pointer chain to max depth
      run_case("R8", 4, STORE + 2, 0, 1'b0);  // store overflow on load

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule